// File: doc/BRIEF.md
# Time-Multiplexed Multi-Channel FIR Filter

The block filters several independent sample streams with one shared multiply-accumulate datapath. A sample is offered with a valid strobe and a channel index. The block stores it in that channel's history RAM. It then steps through every tap, one tap per clock. Each tap multiplies a stored sample by that channel's coefficient for the tap. The block returns one filtered result, tagged with the channel that produced it. The design suits streams whose sample rate is low compared with the clock. While a tap loop is in progress, `busy_o` is high and no new sample is taken.

Coefficients live in a RAM behind a simple memory-mapped port. Software can write coefficients and read them back. Each channel has its own set of coefficients, so channels can use the same response or different ones. Each product is narrowed to an internal width before it is summed. The sum is narrowed again to the output width, with saturation. All arithmetic is two's-complement signed.

Top module: `tdm_fir`

## Requirements
- R1: After reset, `out_valid_o` and `busy_o` are low and `coef_rdata_o` is zero.
- R2: A coefficient is written when `coef_en_i` and `coef_we_i` are both high.
  - The coefficient for channel c and tap k is at address c*NUM_TAPS+k.
  - With `coef_en_i` high and `coef_we_i` low, the addressed coefficient appears on `coef_rdata_o` one clock later.
  - At all other times `coef_rdata_o` holds its value.
- R3: A sample is accepted on a clock edge where `in_valid_i` is high and `busy_o` is low.
  - `busy_o` then stays high for NUM_TAPS+1 cycles.
  - `out_valid_o` rises on the (NUM_TAPS+1)th edge after the accepting edge and is high for exactly one cycle.
  - While `out_valid_o` is high, `out_channel_o` equals the accepted channel.
- R4: The result for channel c is the sum over k = 0..NUM_TAPS-1 of coef[c][k] times the sample accepted k steps earlier on channel c.
  - Each channel keeps its own history.
  - Samples on other channels have no effect on it.
- R5: After reset, any history position that no sample has yet filled counts as zero.
- R6: Each full-width product is arithmetically shifted right by DATA_W+COEF_W-PROD_W, which rounds toward minus infinity. The shifted product is then summed.
- R7: The sum is arithmetically shifted right by OUT_SHIFT, then saturated to the signed OUT_W range.
- R8: A sample offered while `busy_o` is high is dropped. It never enters any history.
- R9: A channel's history keeps only its last NUM_TAPS samples. Older samples stop contributing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample strobe |
| in_channel_i | input | CH_W | Channel of the offered sample |
| in_data_i | input | DATA_W | Signed sample |
| busy_o | output | 1 | Tap loop in progress; new samples are refused |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_channel_o | output | CH_W | Channel of the result |
| out_data_o | output | OUT_W | Signed, saturated result |
| coef_en_i | input | 1 | Coefficient port access |
| coef_we_i | input | 1 | Write when high, read when low |
| coef_addr_i | input | ADDR_W | Coefficient address, channel*NUM_TAPS+tap |
| coef_wdata_i | input | COEF_W | Coefficient write value |
| coef_rdata_o | output | COEF_W | Coefficient read value |

## Verification
The bench uses 4 channels, 4 taps, 8-bit samples and coefficients, a 12-bit internal product, OUT_SHIFT of 2 and a 10-bit output. With these values:
- A product of -1 is large enough to separate floor rounding from truncation toward zero.
- Full-scale inputs reach both saturation limits within four samples.
- The history wraps after only four samples, and the scale is small enough that every expected value can be worked out with integers in the bench.

// File: rtl/tdm_fir_pkg.sv
package tdm_fir_pkg;
  typedef struct packed {
    logic valid;
    logic first;
    logic last;
    logic mask;
  } tap_ctl_t;
endpackage

// File: rtl/tdm_fir_coef_ram.sv
module tdm_fir_coef_ram #(
  parameter int COEF_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [COEF_W-1:0] wdata_i,
  output logic [COEF_W-1:0] rdata_o,
  input  logic [ADDR_W-1:0] mac_addr_i,
  output logic [COEF_W-1:0] mac_data_o
);
  logic [COEF_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem[addr_i] <= wdata_i;
    mac_data_o <= mem[mac_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (en_i && !we_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/tdm_fir_hist_ram.sv
module tdm_fir_hist_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/tdm_fir_mac.sv
module tdm_fir_mac
  import tdm_fir_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int COEF_W    = 8,
  parameter int PROD_W    = 12,
  parameter int ACC_W     = 15,
  parameter int OUT_W     = 10,
  parameter int OUT_SHIFT = 2,
  parameter int CH_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tap_ctl_t          ctl_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic              out_valid_o,
  output logic [CH_W-1:0]   out_channel_o,
  output logic [OUT_W-1:0]  out_data_o
);
  localparam int FULL_W     = DATA_W + COEF_W;
  localparam int PROD_SHIFT = FULL_W - PROD_W;

  logic        [FULL_W-1:0] full;
  logic signed [FULL_W-1:0] prod_sh;
  logic        [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  term, acc_q, acc_next, scaled;
  logic signed [ACC_W-1:0]  sat_max, sat_min;
  logic        [OUT_W-1:0]  sat_val;

  // sign-extended operands; low FULL_W bits of the product are exact
  assign full    = {{COEF_W{sample_i[DATA_W-1]}}, sample_i} *
                   {{DATA_W{coef_i[COEF_W-1]}}, coef_i};
  assign prod_sh = $signed(full) >>> PROD_SHIFT;
  assign prod    = prod_sh[PROD_W-1:0];
  assign term    = ctl_i.mask ? {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod} : '0;
  assign acc_next = (ctl_i.first ? '0 : acc_q) + term;
  assign scaled   = acc_next >>> OUT_SHIFT;

  assign sat_max = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  assign sat_min = ~sat_max;

  always_comb begin
    if (scaled > sat_max)      sat_val = sat_max[OUT_W-1:0];
    else if (scaled < sat_min) sat_val = sat_min[OUT_W-1:0];
    else                       sat_val = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q         <= '0;
      out_valid_o   <= 1'b0;
      out_channel_o <= '0;
      out_data_o    <= '0;
    end else begin
      if (ctl_i.valid) acc_q <= acc_next;
      out_valid_o <= ctl_i.valid && ctl_i.last;
      if (ctl_i.valid && ctl_i.last) begin
        out_data_o    <= sat_val;
        out_channel_o <= ch_i;
      end
    end
  end
endmodule

// File: rtl/tdm_fir.sv
module tdm_fir
  import tdm_fir_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int COEF_W    = 8,
  parameter int NUM_CH    = 4,
  parameter int NUM_TAPS  = 4,
  parameter int PROD_W    = 12,
  parameter int OUT_W     = 10,
  parameter int OUT_SHIFT = 2,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W   = $clog2(NUM_CH * NUM_TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [CH_W-1:0]   in_channel_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              busy_o,
  output logic              out_valid_o,
  output logic [CH_W-1:0]   out_channel_o,
  output logic [OUT_W-1:0]  out_data_o,
  input  logic              coef_en_i,
  input  logic              coef_we_i,
  input  logic [ADDR_W-1:0] coef_addr_i,
  input  logic [COEF_W-1:0] coef_wdata_i,
  output logic [COEF_W-1:0] coef_rdata_o
);
  localparam int TAP_W = $clog2(NUM_TAPS);
  localparam int CNT_W = TAP_W + 1;
  localparam int DEPTH = NUM_CH * NUM_TAPS;
  localparam int ACC_W = PROD_W + TAP_W + 1;

  logic [TAP_W-1:0] wptr_q [NUM_CH];
  logic [CNT_W-1:0] fill_q [NUM_CH];

  logic              issuing_q;
  logic [TAP_W-1:0]  k_q, base_q;
  logic [CNT_W-1:0]  cur_fill_q;
  logic [CH_W-1:0]   ch_q;
  tap_ctl_t          ctl_q;
  logic              accept;
  logic [TAP_W-1:0]  in_ptr, in_ptr_nxt;
  logic [CNT_W-1:0]  in_fill_nxt;
  logic [CNT_W-1:0]  back_idx;
  logic [ADDR_W-1:0] hist_waddr, hist_raddr, coef_raddr;
  logic [DATA_W-1:0] hist_rdata;
  logic [COEF_W-1:0] coef_mac;

  assign busy_o = issuing_q || ctl_q.valid;
  assign accept = in_valid_i && !busy_o;

  assign in_ptr      = wptr_q[in_channel_i];
  assign in_ptr_nxt  = (in_ptr == TAP_W'(NUM_TAPS - 1)) ? '0 : in_ptr + 1'b1;
  assign in_fill_nxt = (fill_q[in_channel_i] == CNT_W'(NUM_TAPS)) ?
                       CNT_W'(NUM_TAPS) : fill_q[in_channel_i] + 1'b1;

  // position of the sample k steps old in the channel's circular buffer
  assign back_idx = (base_q >= k_q) ? CNT_W'(base_q) - CNT_W'(k_q)
                                    : CNT_W'(base_q) + CNT_W'(NUM_TAPS) - CNT_W'(k_q);

  assign hist_waddr = ADDR_W'(in_channel_i) * ADDR_W'(NUM_TAPS) + ADDR_W'(in_ptr);
  assign hist_raddr = ADDR_W'(ch_q) * ADDR_W'(NUM_TAPS) + ADDR_W'(back_idx);
  assign coef_raddr = ADDR_W'(ch_q) * ADDR_W'(NUM_TAPS) + ADDR_W'(k_q);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wptr_q[c] <= '0;
        fill_q[c] <= '0;
      end else if (accept && (in_channel_i == CH_W'(c))) begin
        wptr_q[c] <= in_ptr_nxt;
        fill_q[c] <= in_fill_nxt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issuing_q  <= 1'b0;
      k_q        <= '0;
      base_q     <= '0;
      cur_fill_q <= '0;
      ch_q       <= '0;
      ctl_q      <= '0;
    end else begin
      if (accept) begin
        issuing_q  <= 1'b1;
        k_q        <= '0;
        base_q     <= in_ptr;
        cur_fill_q <= in_fill_nxt;
        ch_q       <= in_channel_i;
      end else if (issuing_q) begin
        k_q <= k_q + 1'b1;
        if (k_q == TAP_W'(NUM_TAPS - 1)) issuing_q <= 1'b0;
      end
      ctl_q.valid <= issuing_q;
      ctl_q.first <= issuing_q && (k_q == '0);
      ctl_q.last  <= issuing_q && (k_q == TAP_W'(NUM_TAPS - 1));
      ctl_q.mask  <= issuing_q && (CNT_W'(k_q) < cur_fill_q);
    end
  end

  tdm_fir_hist_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_hist (
    .clk_i   (clk_i),
    .we_i    (accept),
    .waddr_i (hist_waddr),
    .wdata_i (in_data_i),
    .raddr_i (hist_raddr),
    .rdata_o (hist_rdata)
  );

  tdm_fir_coef_ram #(.COEF_W(COEF_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_coef (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (coef_en_i),
    .we_i       (coef_we_i),
    .addr_i     (coef_addr_i),
    .wdata_i    (coef_wdata_i),
    .rdata_o    (coef_rdata_o),
    .mac_addr_i (coef_raddr),
    .mac_data_o (coef_mac)
  );

  tdm_fir_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .PROD_W(PROD_W), .ACC_W(ACC_W),
    .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT), .CH_W(CH_W)
  ) u_mac (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctl_i         (ctl_q),
    .ch_i          (ch_q),
    .sample_i      (hist_rdata),
    .coef_i        (coef_mac),
    .out_valid_o   (out_valid_o),
    .out_channel_o (out_channel_o),
    .out_data_o    (out_data_o)
  );
endmodule

// File: rtl/tdm_fir_chk.sv
module tdm_fir_chk #(
  parameter int NUM_TAPS = 4,
  parameter int CH_W     = 2,
  parameter int COEF_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [CH_W-1:0]   in_channel_i,
  input logic              busy_o,
  input logic              out_valid_o,
  input logic [CH_W-1:0]   out_channel_o,
  input logic              coef_en_i,
  input logic              coef_we_i,
  input logic [COEF_W-1:0] coef_rdata_o
);
  logic [15:0]     busy_cnt;
  logic [CH_W-1:0] last_ch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt <= '0;
      last_ch  <= '0;
    end else if (in_valid_i && !busy_o) begin
      busy_cnt <= '0;
      last_ch  <= in_channel_i;
    end else if (busy_o && busy_cnt != 16'hffff) begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  p_out_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  p_accept_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !busy_o) |=> busy_o);

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (busy_cnt == 16'(NUM_TAPS + 1)));

  p_out_channel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_channel_o == last_ch));

  p_rdata_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(coef_en_i && !coef_we_i) |=> $stable(coef_rdata_o));

  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && busy_o && busy_cnt < 16'(NUM_TAPS)) |=> (busy_o && busy_cnt != 16'd0));
endmodule

bind tdm_fir tdm_fir_chk #(.NUM_TAPS(NUM_TAPS), .CH_W(CH_W), .COEF_W(COEF_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_channel_i  (in_channel_i),
  .busy_o        (busy_o),
  .out_valid_o   (out_valid_o),
  .out_channel_o (out_channel_o),
  .coef_en_i     (coef_en_i),
  .coef_we_i     (coef_we_i),
  .coef_rdata_o  (coef_rdata_o)
);

// File: tb/sim_tdm_fir.sv
`timescale 1ns/1ps
module sim_tdm_fir;
  localparam int DW = 8, CW = 8, NCH = 4, NT = 4, PW = 12, OW = 10, OSH = 2;
  localparam int PSH = DW + CW - PW;
  localparam int SMAX = (1 << (OW - 1)) - 1;
  localparam int SMIN = -(1 << (OW - 1));

  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [1:0] in_ch = 0;
  logic [DW-1:0] in_data = 0;
  logic busy, out_valid;
  logic [1:0] out_ch;
  logic [OW-1:0] out_data;
  logic c_en = 0, c_we = 0;
  logic [3:0] c_addr = 0;
  logic [CW-1:0] c_wdata = 0;
  logic [CW-1:0] c_rdata;

  int checks = 0, fails = 0;
  int coef [NCH*NT];
  int hx [NCH][NT];

  always #2 clk = ~clk;

  tdm_fir #(.DATA_W(DW), .COEF_W(CW), .NUM_CH(NCH), .NUM_TAPS(NT),
            .PROD_W(PW), .OUT_W(OW), .OUT_SHIFT(OSH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_channel_i(in_ch),
    .in_data_i(in_data), .busy_o(busy), .out_valid_o(out_valid),
    .out_channel_o(out_ch), .out_data_o(out_data), .coef_en_i(c_en),
    .coef_we_i(c_we), .coef_addr_i(c_addr), .coef_wdata_i(c_wdata),
    .coef_rdata_o(c_rdata));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic coef_wr(int a, int v);
    @(negedge clk);
    c_en = 1; c_we = 1; c_addr = a[3:0]; c_wdata = v[CW-1:0];
    coef[a] = v;
    @(negedge clk);
    c_en = 0; c_we = 0;
  endtask

  task automatic coef_rd_chk(int a);
    @(negedge clk);
    c_en = 1; c_we = 0; c_addr = a[3:0];
    @(negedge clk);
    c_en = 0; c_addr = ~a[3:0];
    chk($signed(c_rdata) == coef[a], "R2 readback", $signed(c_rdata), coef[a]);
    @(negedge clk);
    chk($signed(c_rdata) == coef[a], "R2 hold", $signed(c_rdata), coef[a]);
  endtask

  function automatic int model_push(int ch, int d);
    int s = 0;
    for (int k = NT - 1; k > 0; k--) hx[ch][k] = hx[ch][k-1];
    hx[ch][0] = d;
    for (int k = 0; k < NT; k++) s += (hx[ch][k] * coef[ch*NT+k]) >>> PSH;
    s = s >>> OSH;
    if (s > SMAX) s = SMAX;
    if (s < SMIN) s = SMIN;
    return s;
  endfunction

  task automatic send(int ch, int d, bit inject, string req);
    int exp, lat;
    exp = model_push(ch, d);
    @(negedge clk);
    while (busy) @(negedge clk);
    in_valid = 1; in_ch = ch[1:0]; in_data = d[DW-1:0];
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        if (inject) begin in_ch = ch[1:0]; in_data = ~d[DW-1:0]; end
        else in_valid = 0;
      end
      if (lat == 3) in_valid = 0;
    end while (!out_valid && lat < 40);
    chk(lat == NT + 2, "R3 latency", lat, NT + 2);
    chk(out_ch == ch[1:0], "R3 channel", out_ch, ch);
    chk(!busy, "R3 busy released", busy, 0);
    chk($signed(out_data) == exp, req, $signed(out_data), exp);
    @(negedge clk);
    chk(!out_valid, "R3 single pulse", out_valid, 0);
  endtask

  task automatic t_reset;
    chk(!out_valid, "R1 out_valid", out_valid, 0);
    chk(!busy, "R1 busy", busy, 0);
    chk(c_rdata == 0, "R1 rdata", c_rdata, 0);
  endtask

  task automatic t_coef;
    for (int a = 0; a < NCH*NT; a++) coef_wr(a, 0);
    coef_wr(0, 16); coef_wr(1, 32); coef_wr(2, -48); coef_wr(3, 64);
    coef_wr(4, 127); coef_wr(5, -128); coef_wr(6, 5); coef_wr(7, 1);
    for (int k = 0; k < NT; k++) coef_wr(8 + k, 127);
    coef_wr(12, 1);
    coef_rd_chk(2); coef_rd_chk(5); coef_rd_chk(12);
  endtask

  task automatic t_fill;
    send(0, 10, 0, "R5 first sample only");
    send(0, -20, 0, "R5 two samples");
    send(0, 33, 0, "R4 three taps");
  endtask

  task automatic t_channels;
    send(1, 50, 0, "R4 ch1 a");
    send(0, 7, 0, "R4 ch0 full");
    send(1, -90, 0, "R4 ch1 b");
    send(0, 100, 0, "R4 ch0 interleaved");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 6; i++) send(1, 17 * i - 40, 0, "R9 wrap");
  endtask

  task automatic t_ignore;
    send(0, 45, 1, "R8 busy inject");
    send(0, -3, 0, "R8 history unaffected");
  endtask

  task automatic t_floor;
    send(3, -1, 0, "R6 floor of -1");
    send(3, 1, 0, "R6 tiny positive");
    send(3, 31, 0, "R6 coef1 tap0");
  endtask

  task automatic t_sat;
    for (int i = 0; i < 4; i++) send(2, 127, 0, "R7 positive saturate");
    for (int i = 0; i < 4; i++) send(2, -128, 0, "R7 negative saturate");
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) for (int k = 0; k < NT; k++) hx[c][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_coef();
    t_fill();
    t_channels();
    t_wrap();
    t_ignore();
    t_floor();
    t_sat();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule